// File: doc/BRIEF.md
# Variable-Frame SPI Master with Entry Queues

This block is an SPI master (mode 0) that sits between two eight-entry queues. Software-side logic writes transmit entries into one queue. Each entry holds a 16-bit data word, a frame length of 4 to 16 bits and a continue flag. For each entry the engine drives exactly that many SCK cycles. On those clocks it shifts the data out on MOSI and captures MISO. It then writes exactly one 32-bit word into the receive queue. A transmit entry therefore always yields a receive entry, including entries that are sent only to clock read data in.

Chip select falls before the first frame. It stays low across every entry whose continue flag is set, so a transfer can run for any number of entries, such as a long streaming memory read. After a frame with the flag clear, chip select returns high.

Both queue ports use valid/ready:
- **Transmit port:** `tx_ready` is low only while the transmit queue is full. An entry is taken on a clock edge where `tx_valid` and `tx_ready` are both high. A write offered while `tx_ready` is low is dropped.
- **Receive port:** `rx_valid` is high while the receive queue holds data. A word leaves on an edge where `rx_valid` and `rx_ready` are both high. Raising `rx_ready` while the queue is empty does nothing.
- **Back-pressure:** if the receive queue is full, the engine waits before it starts the next frame, so no data is lost. If the transmit queue runs dry while chip select is held, SCK stops low and chip select stays low.

Top module: `spi_frame_master`

## Requirements
- R1: The frame length field `tx_len` encodes N-1. The values 0, 1 and 2 are raised to 3, giving N = 4. Each transmit entry produces exactly N rising SCK edges.
- R2: MOSI carries `tx_data` bit N-1 first, then the lower bits in descending order. MOSI changes only while SCK is low and holds steady while SCK is high.
- R3: MISO is sampled on each rising SCK edge. The first bit sampled lands in bit N-1 of the receive word and the last in bit 0. Bits 31 down to N read as zero.
- R4: Every transmit entry produces exactly one receive word, and receive words leave in the same order that transmit entries were accepted.
- R5: After reset, `spi_cs_n` is high, `spi_sck` is low, `tx_ready` is high and `rx_valid` is low. SCK is low whenever chip select is high.
- R6: When an entry has `tx_cont` = 1, chip select stays low after its frame. If no further entry is queued, SCK stays low and chip select stays low until more entries arrive. When `tx_cont` = 0, chip select rises after the frame.
- R7: Chip select falls at least one SCK half-period before the first rising edge. It rises no earlier than one half-period after the last falling edge.
- R8: While the receive queue is full, no new frame starts and no receive word is dropped or overwritten.
- R9: A write offered while `tx_ready` is low has no effect. A read request while `rx_valid` is low has no effect.
- R10: One SCK period lasts 2 × `sck_half` system clocks. A `sck_half` value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_half | input | 8 | SCK half-period in system clocks; 0 behaves as 1 |
| tx_valid | input | 1 | Transmit entry offered |
| tx_ready | output | 1 | Transmit queue not full |
| tx_data | input | 16 | Frame data, right-aligned |
| tx_len | input | 4 | Frame length minus one |
| tx_cont | input | 1 | Keep chip select low after this frame |
| rx_valid | output | 1 | Receive queue not empty |
| rx_ready | input | 1 | Consumer takes the head word |
| rx_data | output | 32 | Received word, upper bits zero |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Two collisions matter most.

The first is a consumer read that frees a receive slot in the same cycle the engine is deciding whether to start the next frame. The bench provokes it by stalling `rx_ready` until the receive queue fills and the transmit queue backs up. It then releases `rx_ready`, so the drain and the restart overlap.

The second is a producer write that lands in the same cycle the engine pops the transmit head. It arises from back-to-back writes while frames run.

Both collisions are judged by the scoreboard:
- The receive words and MOSI bit stream must match the predicted order exactly, with nothing missing and nothing extra.
- While stalled, the count of MOSI bits still outstanding must equal the lengths of the frames held back.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 4;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [LEN_W-1:0]  len_m1;
    logic              cont;
  } tx_entry_t;

  localparam int ENTRY_W = $bits(tx_entry_t);
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine #(
  parameter int DW = 16,
  parameter int LW = 4,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] half,
  input  logic          tx_avail,
  input  logic [DW-1:0] tx_data,
  input  logic [LW-1:0] tx_len_m1,
  input  logic          tx_cont,
  output logic          tx_pop,
  input  logic          rx_full,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          sck,
  output logic          mosi,
  output logic          cs_n,
  input  logic          miso
);
  localparam logic [LW-1:0] TOP_BIT = LW'(DW-1);
  localparam logic [LW-1:0] MIN_LM1 = LW'(3);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_GAP, S_HOLD} state_t;

  state_t        state;
  logic [DW-1:0] tsh, rsh, aligned;
  logic [LW-1:0] left, eff_lm1;
  logic [HW-1:0] hc, hmax;
  logic          cont_q, tick, start;

  assign hmax    = (half == '0) ? HW'(1) : half;
  assign tick    = (hc >= hmax - 1'b1);
  assign eff_lm1 = (tx_len_m1 < MIN_LM1) ? MIN_LM1 : tx_len_m1;
  assign aligned = tx_data << (TOP_BIT - eff_lm1);
  // The pending push counts as occupied space so a full queue is never overrun.
  assign start   = (state == S_IDLE || state == S_GAP) && tx_avail && !rx_full && !rx_push;
  assign tx_pop  = start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      tsh     <= '0;
      rsh     <= '0;
      left    <= '0;
      hc      <= '0;
      cont_q  <= 1'b0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= 1'b1;
      rx_push <= 1'b0;
      rx_word <= '0;
    end else begin
      rx_push <= 1'b0;
      unique case (state)
        S_IDLE, S_GAP: begin
          if (start) begin
            tsh    <= aligned;
            rsh    <= '0;
            left   <= eff_lm1;
            cont_q <= tx_cont;
            mosi   <= aligned[DW-1];
            cs_n   <= 1'b0;
            hc     <= '0;
            state  <= S_LOW;
          end
        end
        S_LOW: begin
          hc <= hc + 1'b1;
          if (tick) begin
            hc    <= '0;
            sck   <= 1'b1;
            rsh   <= {rsh[DW-2:0], miso};
            state <= S_HIGH;
          end
        end
        S_HIGH: begin
          hc <= hc + 1'b1;
          if (tick) begin
            hc  <= '0;
            sck <= 1'b0;
            if (left == '0) begin
              rx_push <= 1'b1;
              rx_word <= rsh;
              state   <= cont_q ? S_GAP : S_HOLD;
            end else begin
              tsh   <= tsh << 1;
              mosi  <= tsh[DW-2];
              left  <= left - 1'b1;
              state <= S_LOW;
            end
          end
        end
        S_HOLD: begin
          hc <= hc + 1'b1;
          if (tick) begin
            hc    <= '0;
            cs_n  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int HALF_W = 8,
  parameter int RX_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] sck_half,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              tx_cont,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [RX_W-1:0]   rx_data,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  tx_entry_t         tx_in, tx_head;
  logic              tx_full, tx_empty, eng_tx_pop;
  logic              rx_full, rx_empty, eng_rx_push;
  logic [DATA_W-1:0] eng_rx_word, rx_head;

  assign tx_in    = '{data: tx_data, len_m1: tx_len, cont: tx_cont};
  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;
  assign rx_data  = {{(RX_W-DATA_W){1'b0}}, rx_head};

  spi_fm_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_valid), .din(tx_in),
    .pop(eng_tx_pop), .dout(tx_head),
    .full(tx_full), .empty(tx_empty)
  );

  spi_fm_engine #(.DW(DATA_W), .LW(LEN_W), .HW(HALF_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .half(sck_half),
    .tx_avail(!tx_empty), .tx_data(tx_head.data),
    .tx_len_m1(tx_head.len_m1), .tx_cont(tx_head.cont),
    .tx_pop(eng_tx_pop),
    .rx_full(rx_full), .rx_push(eng_rx_push), .rx_word(eng_rx_word),
    .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n), .miso(spi_miso)
  );

  spi_fm_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(eng_rx_push), .din(eng_rx_word),
    .pop(rx_ready), .dout(rx_head),
    .full(rx_full), .empty(rx_empty)
  );
endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker (
  input logic clk,
  input logic rst_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic rx_push,
  input logic rx_full
);
  a_r5_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r2_mosi_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  a_r7_cs_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !spi_sck);

  a_r7_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (!spi_sck && !$past(spi_sck)));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
endmodule

bind spi_frame_master spi_fm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .rx_push(eng_rx_push), .rx_full(rx_full)
);

// File: tb/test_spi_frame_master.sv
module test_spi_frame_master;
  localparam int PERIOD = 10;
  localparam logic [31:0] PAT = 32'hC3A5_96E1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sck_half = 8'd2;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = '0;
  logic [3:0]  tx_len = '0;
  logic        tx_cont = 1'b0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [31:0] rx_data;
  logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

  int checks = 0;
  int errors = 0;
  int unsigned kk = 0;
  int unsigned k_pred = 0;
  logic [31:0] exp_rx[$];
  logic        exp_mosi[$];

  always #(PERIOD/2) clk = ~clk;

  spi_frame_master i_spi_frame_master (
    .clk(clk), .rst_n(rst_n), .sck_half(sck_half),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_len(tx_len), .tx_cont(tx_cont),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  // Slave model: presents the next pattern bit after every falling SCK edge.
  assign spi_miso = PAT[kk % 32];
  always @(negedge spi_sck) if (rst_n) kk = kk + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // MOSI monitor (R1, R2)
  always @(posedge spi_sck) if (rst_n) begin
    if (exp_mosi.size() == 0) chk(1'b0, "R1 extra SCK edge", 32'(spi_mosi), 32'hx);
    else begin
      logic b;
      b = exp_mosi.pop_front();
      chk(spi_mosi == b, "R2 MOSI bit", 32'(spi_mosi), 32'(b));
    end
  end

  // Receive monitor (R3, R4)
  always @(negedge clk) if (rst_n && rx_valid && rx_ready) begin
    if (exp_rx.size() == 0) chk(1'b0, "R4 extra receive word", rx_data, 32'hx);
    else begin
      logic [31:0] e;
      e = exp_rx.pop_front();
      chk(rx_data == e, "R3 receive word", rx_data, e);
    end
  end

  task automatic push_entry(input logic [15:0] d, input logic [3:0] lm1, input logic c);
    int n;
    logic [31:0] e;
    n = ((lm1 < 4'd3) ? 3 : int'(lm1)) + 1;
    e = '0;
    for (int i = 0; i < n; i++) begin
      exp_mosi.push_back(d[n-1-i]);
      e[n-1-i] = PAT[(k_pred + i) % 32];
    end
    k_pred += n;
    exp_rx.push_back(e);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_len = lm1; tx_cont = c;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_rx.size() != 0 || !spi_cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_rx_ready(input logic v);
    @(posedge clk);
    rx_ready <= v;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5 reset state
    chk(spi_cs_n == 1'b1, "R5 cs_n after reset", 32'(spi_cs_n), 1);
    chk(spi_sck == 1'b0, "R5 sck after reset", 32'(spi_sck), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_ready == 1'b1, "R5 tx_ready after reset", 32'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R9 read of empty queue ignored", 32'(rx_valid), 0);

    // Mixed lengths, clamped length (R1), chained and single frames (R6)
    push_entry(16'h00A5, 4'd7, 1'b0);
    wait_idle();
    chk(spi_cs_n == 1'b1, "R6 cs_n rises after final frame", 32'(spi_cs_n), 1);
    push_entry(16'h1234, 4'd15, 1'b1);
    push_entry(16'h000B, 4'd3, 1'b1);
    push_entry(16'h0ABC, 4'd11, 1'b0);
    push_entry(16'hFFFD, 4'd1, 1'b0);
    wait_idle();

    // R10 SCK period
    sck_half = 8'd3;
    push_entry(16'h5A5A, 4'd15, 1'b0);
    begin
      time t0, t1;
      @(posedge spi_sck); t0 = $time;
      @(posedge spi_sck); t1 = $time;
      chk((t1 - t0) == 6 * PERIOD, "R10 period half=3", 32'(t1 - t0), 32'(6 * PERIOD));
    end
    wait_idle();
    sck_half = 8'd0;
    push_entry(16'h0F0F, 4'd9, 1'b0);
    begin
      time t0, t1;
      @(posedge spi_sck); t0 = $time;
      @(posedge spi_sck); t1 = $time;
      chk((t1 - t0) == 2 * PERIOD, "R10 period half=0", 32'(t1 - t0), 32'(2 * PERIOD));
    end
    wait_idle();
    sck_half = 8'd2;

    // R6 pause with chip select held
    push_entry(16'h00C3, 4'd7, 1'b1);
    while (exp_rx.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 1'b0, "R6 cs_n held during pause", 32'(spi_cs_n), 0);
    chk(spi_sck == 1'b0, "R6 sck low during pause", 32'(spi_sck), 0);
    push_entry(16'h003C, 4'd5, 1'b0);
    wait_idle();
    chk(spi_cs_n == 1'b1, "R6 cs_n rises after chain", 32'(spi_cs_n), 1);

    // R8 stall on full receive queue, R9 ignored write
    set_rx_ready(1'b0);
    for (int i = 0; i < 16; i++)
      push_entry(16'(i * 16'h1357), 4'(4 + (i % 12)), (i != 15));
    repeat (200) @(negedge clk);
    begin
      int held;
      held = 0;
      for (int i = 8; i < 16; i++) held += 5 + (i % 12);
      chk(exp_mosi.size() == held, "R8 frames held while rx full", 32'(exp_mosi.size()), 32'(held));
    end
    chk(tx_ready == 1'b0, "R9 tx queue full", 32'(tx_ready), 0);
    chk(spi_cs_n == 1'b0, "R8 cs_n low while stalled", 32'(spi_cs_n), 0);
    tx_valid = 1'b1; tx_data = 16'hDEAD; tx_len = 4'd15; tx_cont = 1'b0;
    repeat (10) @(negedge clk);
    tx_valid = 1'b0;
    set_rx_ready(1'b1);
    wait_idle();
    repeat (50) @(negedge clk);
    chk(exp_rx.size() == 0, "R4 all receive words delivered", 32'(exp_rx.size()), 0);
    chk(exp_mosi.size() == 0, "R1 all bits clocked", 32'(exp_mosi.size()), 0);
    chk(rx_valid == 1'b0, "R9 dropped write produced no word", 32'(rx_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule